// File: doc/BRIEF.md
# Wide-to-Narrow Burst Command Splitter

This block sits between a master that issues burst commands in 64-bit beats and a target bus that moves 32-bit words and takes at most 16 words per burst. Each source command carries a start address, a beat count and a burst kind. The block turns it into a short series of target commands. Each target command has a start address, a word count, a direction and a flag that marks the final piece. The block moves no data. It only produces the command stream, with a valid/ready handshake on each side.

One source beat becomes two target words. The resulting word total is cut into 16-word pieces. The final piece carries whatever is left over, which is always between 2 and 16 words. For an incrementing command, each piece starts 64 bytes above the previous one. For a fixed-address command, every piece reuses the original address. The block holds one source command at a time and accepts the next one only after the final piece of the current command has been taken.

Top module: `dw_burst_splitter`

## Requirements
- R1: After reset, `src_ready` is 1 and `tgt_valid` is 0.
- R2: A source command of B beats (`src_beats_m1` = B-1, B from 1 to 256) produces exactly ceil(2*B/16) target commands. The first target command is offered in the cycle after the source handshake.
- R3: Every target command except the final one has `tgt_words` = 16 and `tgt_last` = 0.
- R4: The final target command has `tgt_last` = 1 and `tgt_words` = 2*B - 16*(N-1), where N is the number of pieces. This value lies between 2 and 16.
- R5: When `src_fixed` = 0 (incrementing), piece i has `tgt_addr` = start address + 64*i.
- R6: When `src_fixed` = 1 (fixed address), every piece has `tgt_addr` equal to the start address.
- R7: Every piece carries the `src_write` value captured from its source command.
- R8: `src_ready` is 0 while any piece of a command is still pending. The next source command is accepted only after the final piece has been handed off.
- R9: While `tgt_valid` is 1 and `tgt_ready` is 0, all target outputs hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_valid | input | 1 | Source command offered |
| src_ready | output | 1 | Source command accepted this cycle when high with src_valid |
| src_addr | input | ADDR_W | Start byte address, word aligned |
| src_beats_m1 | input | LEN_W | Beat count minus one |
| src_fixed | input | 1 | 0 = incrementing burst, 1 = fixed-address burst |
| src_write | input | 1 | Direction: 1 = write, 0 = read |
| tgt_valid | output | 1 | Target command offered |
| tgt_ready | input | 1 | Target command taken this cycle when high with tgt_valid |
| tgt_addr | output | ADDR_W | Start byte address of this piece |
| tgt_words | output | clog2(TGT_MAX+1) | Word count of this piece |
| tgt_last | output | 1 | Final piece of the current source command |
| tgt_write | output | 1 | Direction of this piece |

## Verification
The assertions take it for granted that `src_addr` is word aligned and that an incrementing command does not run past the top of the address space. The address-step property relies on plain modular addition of 64. The stimulus uses word-aligned start addresses that stay well below the wrap point. It sweeps every beat count from 1 to 256 in both burst kinds, alternates the direction, and throttles `tgt_ready` with a pseudo-random pattern so that held offers get exercised.

// File: rtl/dw_burst_splitter_pkg.sv
package dw_burst_splitter_pkg;
   typedef enum logic {
      KIND_INCR  = 1'b0,
      KIND_FIXED = 1'b1
   } burst_kind_e;
endpackage

// File: rtl/dw_burst_word_count.sv
module dw_burst_word_count #(
   parameter int LEN_W   = 8,
   parameter int RATIO   = 2,
   parameter int WCNT_W  = 10
) (
   input  logic [LEN_W-1:0]  beats_m1,
   output logic [WCNT_W-1:0] words
);
   localparam int RSH = (RATIO > 1) ? $clog2(RATIO) : 0;

   logic [WCNT_W-1:0] beats;
   assign beats = WCNT_W'(beats_m1) + WCNT_W'(1);

   generate
      if (RATIO == 1) begin : g_same_width
         assign words = beats;
      end else begin : g_widen
         assign words = beats << RSH;
      end
   endgenerate
endmodule

// File: rtl/dw_burst_addr_step.sv
module dw_burst_addr_step #(
   parameter int ADDR_W = 32,
   parameter int STEP   = 64
) (
   input  logic              fixed,
   input  logic [ADDR_W-1:0] cur,
   output logic [ADDR_W-1:0] nxt
);
   generate
      if (STEP == 0) begin : g_no_step
         assign nxt = cur;
      end else begin : g_step
         assign nxt = fixed ? cur : cur + ADDR_W'(STEP);
      end
   endgenerate
endmodule

// File: rtl/dw_burst_sequencer.sv
module dw_burst_sequencer
   import dw_burst_splitter_pkg::*;
#(
   parameter int ADDR_W  = 32,
   parameter int WCNT_W  = 10,
   parameter int BW_W    = 5,
   parameter int TGT_MAX = 16,
   parameter int STEP    = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_valid,
   output logic              src_ready,
   input  logic [ADDR_W-1:0] src_addr,
   input  logic [WCNT_W-1:0] src_words,
   input  logic              src_fixed,
   input  logic              src_write,
   output logic              tgt_valid,
   input  logic              tgt_ready,
   output logic [ADDR_W-1:0] tgt_addr,
   output logic [BW_W-1:0]   tgt_words,
   output logic              tgt_last,
   output logic              tgt_write,
   output logic              cur_fixed
);
   localparam logic [WCNT_W-1:0] MAX_W = WCNT_W'(TGT_MAX);

   logic              busy_q;
   logic [ADDR_W-1:0] addr_q;
   logic [ADDR_W-1:0] addr_nxt;
   logic [WCNT_W-1:0] rem_q;
   burst_kind_e       kind_q;
   logic              write_q;
   logic [WCNT_W-1:0] piece_w;

   assign tgt_last  = (rem_q <= MAX_W);
   assign piece_w   = tgt_last ? rem_q : MAX_W;
   assign tgt_words = BW_W'(piece_w);
   assign tgt_valid = busy_q;
   assign src_ready = !busy_q;
   assign tgt_addr  = addr_q;
   assign tgt_write = write_q;
   assign cur_fixed = (kind_q == KIND_FIXED);

   dw_burst_addr_step #(.ADDR_W(ADDR_W), .STEP(STEP)) step_i (
      .fixed (cur_fixed),
      .cur   (addr_q),
      .nxt   (addr_nxt)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         addr_q  <= '0;
         rem_q   <= '0;
         kind_q  <= KIND_INCR;
         write_q <= 1'b0;
      end else if (!busy_q) begin
         if (src_valid) begin
            busy_q  <= 1'b1;
            addr_q  <= src_addr;
            rem_q   <= src_words;
            kind_q  <= src_fixed ? KIND_FIXED : KIND_INCR;
            write_q <= src_write;
         end
      end else if (tgt_ready) begin
         if (tgt_last) begin
            busy_q <= 1'b0;
         end
         rem_q  <= rem_q - piece_w;
         addr_q <= addr_nxt;
      end
   end
endmodule

// File: rtl/dw_burst_splitter.sv
module dw_burst_splitter #(
   parameter int ADDR_W    = 32,
   parameter int LEN_W     = 8,
   parameter int SRC_BYTES = 8,
   parameter int TGT_BYTES = 4,
   parameter int TGT_MAX   = 16
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           src_valid,
   output logic                           src_ready,
   input  logic [ADDR_W-1:0]              src_addr,
   input  logic [LEN_W-1:0]               src_beats_m1,
   input  logic                           src_fixed,
   input  logic                           src_write,
   output logic                           tgt_valid,
   input  logic                           tgt_ready,
   output logic [ADDR_W-1:0]              tgt_addr,
   output logic [$clog2(TGT_MAX+1)-1:0]   tgt_words,
   output logic                           tgt_last,
   output logic                           tgt_write
);
   localparam int RATIO  = SRC_BYTES / TGT_BYTES;
   localparam int RSH    = (RATIO > 1) ? $clog2(RATIO) : 0;
   localparam int WCNT_W = LEN_W + 1 + RSH;
   localparam int BW_W   = $clog2(TGT_MAX + 1);
   localparam int STEP   = TGT_MAX * TGT_BYTES;

   generate
      if (SRC_BYTES % TGT_BYTES != 0) begin : g_bad_ratio
         $error("source width must be a multiple of target width");
      end
      if ((RATIO & (RATIO - 1)) != 0) begin : g_bad_pow2
         $error("width ratio must be a power of two");
      end
      if (TGT_MAX < RATIO || (TGT_MAX % RATIO) != 0) begin : g_bad_max
         $error("target burst limit must be a multiple of the width ratio");
      end
      if (WCNT_W < BW_W) begin : g_bad_cnt
         $error("word counter narrower than burst size field");
      end
   endgenerate

   logic [WCNT_W-1:0] total_words;
   logic              cur_fixed;

   dw_burst_word_count #(.LEN_W(LEN_W), .RATIO(RATIO), .WCNT_W(WCNT_W)) wc_i (
      .beats_m1 (src_beats_m1),
      .words    (total_words)
   );

   dw_burst_sequencer #(
      .ADDR_W(ADDR_W), .WCNT_W(WCNT_W), .BW_W(BW_W),
      .TGT_MAX(TGT_MAX), .STEP(STEP)
   ) seq_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .src_valid (src_valid),
      .src_ready (src_ready),
      .src_addr  (src_addr),
      .src_words (total_words),
      .src_fixed (src_fixed),
      .src_write (src_write),
      .tgt_valid (tgt_valid),
      .tgt_ready (tgt_ready),
      .tgt_addr  (tgt_addr),
      .tgt_words (tgt_words),
      .tgt_last  (tgt_last),
      .tgt_write (tgt_write),
      .cur_fixed (cur_fixed)
   );
endmodule

// File: rtl/dw_burst_splitter_chk.sv
module dw_burst_splitter_chk #(
   parameter int ADDR_W    = 32,
   parameter int SRC_BYTES = 8,
   parameter int TGT_BYTES = 4,
   parameter int TGT_MAX   = 16
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         src_valid,
   input logic                         src_ready,
   input logic                         tgt_valid,
   input logic                         tgt_ready,
   input logic [ADDR_W-1:0]            tgt_addr,
   input logic [$clog2(TGT_MAX+1)-1:0] tgt_words,
   input logic                         tgt_last,
   input logic                         tgt_write,
   input logic                         cmd_fixed
);
   localparam int RATIO = SRC_BYTES / TGT_BYTES;
   localparam int STEP  = TGT_MAX * TGT_BYTES;

   // R2
   start_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (src_valid && src_ready) |=> tgt_valid);

   // R3
   full_piece_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid && !tgt_last) |-> (int'(tgt_words) == TGT_MAX));

   // R4
   tail_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid && tgt_last) |-> (int'(tgt_words) >= RATIO && int'(tgt_words) <= TGT_MAX));

   // R5
   incr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid && !cmd_fixed && $past(tgt_valid && tgt_ready && !tgt_last))
      |-> (tgt_addr == $past(tgt_addr) + ADDR_W'(STEP)));

   // R6
   fixed_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid && cmd_fixed && $past(tgt_valid && tgt_ready && !tgt_last))
      |-> (tgt_addr == $past(tgt_addr)));

   // R7
   dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid && $past(tgt_valid && tgt_ready && !tgt_last))
      |-> (tgt_write == $past(tgt_write)));

   // R8
   busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid |-> !src_ready);

   // R9
   hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid && !tgt_ready) |=> (tgt_valid && $stable(tgt_addr) && $stable(tgt_words)
                                     && $stable(tgt_last) && $stable(tgt_write)));
endmodule

bind dw_burst_splitter dw_burst_splitter_chk #(
   .ADDR_W(ADDR_W), .SRC_BYTES(SRC_BYTES), .TGT_BYTES(TGT_BYTES), .TGT_MAX(TGT_MAX)
) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .src_valid (src_valid),
   .src_ready (src_ready),
   .tgt_valid (tgt_valid),
   .tgt_ready (tgt_ready),
   .tgt_addr  (tgt_addr),
   .tgt_words (tgt_words),
   .tgt_last  (tgt_last),
   .tgt_write (tgt_write),
   .cmd_fixed (cur_fixed)
);

// File: tb/dw_burst_splitter_tb_top.sv
module dw_burst_splitter_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int ADDR_W     = 32;
   localparam int LEN_W      = 8;
   localparam int TGT_MAX    = 16;
   localparam int WD_LIMIT   = 150000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              src_valid = 1'b0;
   logic              src_ready;
   logic [ADDR_W-1:0] src_addr = '0;
   logic [LEN_W-1:0]  src_beats_m1 = '0;
   logic              src_fixed = 1'b0;
   logic              src_write = 1'b0;
   logic              tgt_valid;
   logic              tgt_ready = 1'b0;
   logic [ADDR_W-1:0] tgt_addr;
   logic [4:0]        tgt_words;
   logic              tgt_last;
   logic              tgt_write;

   int   n_checks = 0;
   int   n_fails  = 0;
   int   cycles   = 0;
   bit   done     = 1'b0;
   logic [7:0] lfsr = 8'hA5;

   always #(CLK_PERIOD/2) clk = ~clk;

   dw_burst_splitter dut_i (
      .clk(clk), .rst_n(rst_n),
      .src_valid(src_valid), .src_ready(src_ready), .src_addr(src_addr),
      .src_beats_m1(src_beats_m1), .src_fixed(src_fixed), .src_write(src_write),
      .tgt_valid(tgt_valid), .tgt_ready(tgt_ready), .tgt_addr(tgt_addr),
      .tgt_words(tgt_words), .tgt_last(tgt_last), .tgt_write(tgt_write)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input longint act, input longint exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (!done && cycles > WD_LIMIT) begin
         n_fails++;
         $display("FAIL watchdog expired after %0d cycles", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   end

   task automatic run_cmd(input int beats, input bit fixed, input bit wr, input int idx);
      logic [ADDR_W-1:0] base;
      int n_exp;
      int piece;
      bit seen_last;
      base  = ADDR_W'(32'h1000_0000 + idx * 32'h404);
      n_exp = (2 * beats + TGT_MAX - 1) / TGT_MAX;
      @(negedge clk);
      src_valid    = 1'b1;
      src_addr     = base;
      src_beats_m1 = LEN_W'(beats - 1);
      src_fixed    = fixed;
      src_write    = wr;
      while (!src_ready) @(negedge clk);
      @(negedge clk);
      src_valid = 1'b0;
      // R2: offered in the cycle after the source handshake
      check(tgt_valid === 1'b1, "R2", "offer after accept", longint'(tgt_valid), 1);
      piece = 0;
      seen_last = 1'b0;
      while (!seen_last) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         tgt_ready = lfsr[0] | lfsr[1];
         if (tgt_valid) begin
            // R8: no new command while pieces are pending
            check(src_ready === 1'b0, "R8", "src_ready while busy", longint'(src_ready), 0);
         end
         if (tgt_valid && tgt_ready) begin
            bit exp_last;
            int exp_words;
            logic [ADDR_W-1:0] exp_addr;
            exp_last  = (piece == n_exp - 1);
            exp_words = exp_last ? 2 * beats - TGT_MAX * (n_exp - 1) : TGT_MAX;
            exp_addr  = fixed ? base : base + ADDR_W'(64 * piece);
            if (exp_last)
               check(tgt_last === 1'b1 && int'(tgt_words) == exp_words, "R4",
                     "final piece words", longint'(tgt_words), exp_words);
            else
               check(tgt_last === 1'b0 && int'(tgt_words) == TGT_MAX, "R3",
                     "full piece words", longint'(tgt_words), TGT_MAX);
            check(tgt_addr === exp_addr, fixed ? "R6" : "R5", "piece address",
                  longint'(tgt_addr), longint'(exp_addr));
            check(tgt_write === wr, "R7", "piece direction", longint'(tgt_write), wr);
            if (tgt_last) seen_last = 1'b1;
            piece++;
            if (piece > n_exp + 1) seen_last = 1'b1;
         end else if (tgt_valid && piece > 0 && (lfsr[2] == 1'b0)) begin
            logic [ADDR_W-1:0] a0;
            a0 = tgt_addr;
            @(negedge clk);
            // R9: held offer does not move
            check(tgt_valid === 1'b1 && tgt_addr === a0, "R9", "held address",
                  longint'(tgt_addr), longint'(a0));
            continue;
         end
         @(negedge clk);
      end
      tgt_ready = 1'b0;
      // R2: total piece count
      check(piece == n_exp, "R2", "piece count", piece, n_exp);
      // R8: ready again once the final piece is gone
      check(src_ready === 1'b1 && tgt_valid === 1'b0, "R8", "idle after final piece",
            longint'(src_ready), 1);
   endtask

   initial begin
      #1;
      // R1: reset state
      check(src_ready === 1'b1, "R1", "src_ready in reset", longint'(src_ready), 1);
      check(tgt_valid === 1'b0, "R1", "tgt_valid in reset", longint'(tgt_valid), 0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(src_ready === 1'b1 && tgt_valid === 1'b0, "R1", "idle after reset",
            longint'(tgt_valid), 0);
      for (int k = 0; k < 2; k++) begin
         for (int b = 1; b <= 256; b++) begin
            run_cmd(b, k[0], b[0], b + 256 * k);
         end
      end
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule